// File: doc/BRIEF.md
# Tick-Counted Watchdog with Sticky Expiry Flag

This block is a 32-bit watchdog that counts down in ticks. A one-cycle tick strobe comes from an external divider that runs at the converter base rate, so loading that rate value gives a one-second window. Software writes the timeout in ticks. Each nonzero write reloads the down-counter and is the keep-alive. A zero write stops the watchdog.

If the count runs out, the block raises a reset request equal to a power-on reset, which the chip's reset logic acts on. Two pieces of state outlive that reset. The first is a sticky expiry flag, read at bit 31 of the status word and cleared by writing 1 to that bit. The second is the status pin: when the output function is enabled, the pin stays an output and drives low.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tick_watchdog`

## Requirements
- R1: After `rst_n` is released, `rst_req`, `sts_flag`, `sts_rd`, `wdo_oe` and `wdo_out` are all 0, and the watchdog is stopped.
- R2: After a write of nonzero value N to `tmo_data` (with `tmo_wr`=1), `rst_req` rises in the cycle that follows the clock edge that samples the N-th tick. It does not rise before then.
- R3: A nonzero timeout write reloads the counter even while it is counting. If a write and a tick fall in the same cycle, the write wins and that tick is not counted.
- R4: A zero timeout write stops the watchdog. Ticks that arrive while it is stopped never cause an expiry.
- R5: An expiry holds `rst_req` at 1 for exactly 4 consecutive cycles, then returns it to 0.
- R6: Expiry sets `sts_flag` in the same cycle that `rst_req` rises. The flag stays set through and after the reset pulse. `sts_rd` shows the flag at bit 31, and every other bit of `sts_rd` reads 0.
- R7: A status write (`sts_wr`=1) with bit 31 of `sts_data` at 1 clears the flag. A status write with bit 31 at 0 leaves the flag unchanged. If a clear and an expiry fall in the same cycle, the flag ends up set.
- R8: `wdo_oe` follows `wdo_en`. `wdo_out` is 1 only when `wdo_en`=1, the watchdog is counting and the flag is clear. In every other case `wdo_out` is 0, including after an expiry.
- R9: After an expiry the watchdog stops, and further ticks cause no second expiry until a new nonzero value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle tick strobe |
| tmo_wr | input | 1 | Timeout register write strobe |
| tmo_data | input | 32 | Timeout value in ticks (0 stops the watchdog) |
| sts_wr | input | 1 | Status register write strobe |
| sts_data | input | 32 | Status write data (1 at bit 31 clears the flag) |
| sts_rd | output | 32 | Status read word (flag at bit 31) |
| sts_flag | output | 1 | Sticky expiry flag |
| rst_req | output | 1 | System reset request pulse |
| wdo_en | input | 1 | Enables the watchdog status pin function |
| wdo_oe | output | 1 | Status pin output enable |
| wdo_out | output | 1 | Status pin level |

## Verification
Two pairs of actions can land in the same cycle. One pair is a keep-alive write and the tick that would have ended the count. The other is a flag clear and the expiry that sets the flag. Directed steps place a reload exactly on the final tick and a bit-31 clear exactly on the expiring tick. The bench then checks that `rst_req` stays low in the first case and that `sts_flag` stays set in the second. Random stimulus also produces these overlaps, and every cycle is compared against a model built from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DEF_CNT_W     = 32;
  localparam int unsigned DEF_FLAG_BIT  = 31;
  localparam int unsigned DEF_PULSE_LEN = 4;

  typedef struct packed {
    logic armed;
    logic expire;
  } wdt_evt_t;
endpackage

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output wdt_pkg::wdt_evt_t evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             expire;

  assign expire = tick && armed && !load && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      armed <= (load_val != '0);
    end else if (tick && armed) begin
      if (cnt == ONE) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign evt.armed  = armed;
  assign evt.expire = expire;

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> (armed && cnt == $past(load_val)));

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !armed);

  assert_stop_after_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed);

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic req
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (start)        left <= LEN;
    else if (left != '0)   left <= left - PW'(1);
  end

  assign req = (left != '0);

  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (left != '0 && !start) |=> (left == $past(left) - PW'(1)));

  assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    left <= LEN);
endmodule

// File: rtl/wdt_status.sv
module wdt_status #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned FLAG_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             flag,
  output logic [REG_W-1:0] rd
);
  localparam logic [REG_W-1:0] MASK = REG_W'(1) << FLAG_BIT;

  logic clr;
  assign clr = wr && ((wdata & MASK) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign rd = flag ? MASK : '0;

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set) |=> !flag);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int unsigned CNT_W     = wdt_pkg::DEF_CNT_W,
  parameter int unsigned FLAG_BIT  = wdt_pkg::DEF_FLAG_BIT,
  parameter int unsigned PULSE_LEN = wdt_pkg::DEF_PULSE_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tmo_wr,
  input  logic [CNT_W-1:0] tmo_data,
  input  logic             sts_wr,
  input  logic [CNT_W-1:0] sts_data,
  output logic [CNT_W-1:0] sts_rd,
  output logic             sts_flag,
  output logic             rst_req,
  input  logic             wdo_en,
  output logic             wdo_oe,
  output logic             wdo_out
);
  wdt_pkg::wdt_evt_t evt;

  wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(tmo_wr), .load_val(tmo_data), .evt(evt)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(evt.expire), .req(rst_req)
  );

  wdt_status #(.REG_W(CNT_W), .FLAG_BIT(FLAG_BIT)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(evt.expire),
    .wr(sts_wr), .wdata(sts_data), .flag(sts_flag), .rd(sts_rd)
  );

  assign wdo_oe  = wdo_en;
  assign wdo_out = wdo_en && evt.armed && !sts_flag;

  assert_pin_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flag && wdo_en) |-> (wdo_oe && !wdo_out));

  assert_req_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> sts_flag);
endmodule

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, tmo_wr = 1'b0, sts_wr = 1'b0, wdo_en = 1'b0;
  logic [31:0] tmo_data = '0, sts_data = '0;
  logic [31:0] sts_rd;
  logic        sts_flag, rst_req, wdo_oe, wdo_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit          m_armed;
  logic [31:0] m_cnt;
  bit          m_flag;
  int          m_pulse;

  always #2.5ns clk = ~clk;

  tick_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tmo_wr(tmo_wr), .tmo_data(tmo_data),
    .sts_wr(sts_wr), .sts_data(sts_data), .sts_rd(sts_rd), .sts_flag(sts_flag),
    .rst_req(rst_req), .wdo_en(wdo_en), .wdo_oe(wdo_oe), .wdo_out(wdo_out)
  );

  function automatic bit exp_req();
    return m_pulse != 0;
  endfunction

  function automatic bit exp_pin();
    return wdo_en && m_armed && !m_flag;
  endfunction

  task automatic model_step();
    bit expire;
    expire = tick && m_armed && !tmo_wr && (m_cnt == 32'd1);
    if (tmo_wr) begin
      m_armed = (tmo_data != 0);
      m_cnt   = tmo_data;
    end else if (tick && m_armed) begin
      if (m_cnt == 32'd1) begin m_armed = 0; m_cnt = 0; end
      else m_cnt = m_cnt - 1;
    end
    if (expire) m_flag = 1;
    else if (sts_wr && sts_data[31]) m_flag = 0;
    if (expire) m_pulse = 4;
    else if (m_pulse > 0) m_pulse = m_pulse - 1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, 32'(rst_req), 32'(exp_req()), "rst_req");
    chk(tag, 32'(sts_flag), 32'(m_flag), "sts_flag");
    chk(tag, sts_rd, m_flag ? 32'h8000_0000 : 32'h0, "sts_rd");
    chk(tag, 32'(wdo_oe), 32'(wdo_en), "wdo_oe");
    chk(tag, 32'(wdo_out), 32'(exp_pin()), "wdo_out");
  endtask

  // drive at negedge, clock in, update model, compare at next negedge
  task automatic step(input bit t, input bit w, input logic [31:0] wd,
                      input bit s, input logic [31:0] sd, input string tag);
    tick = t; tmo_wr = w; tmo_data = wd; sts_wr = s; sts_data = sd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    tick = 0; tmo_wr = 0; sts_wr = 0;
    check_all(tag);
  endtask

  task automatic idle(input int n, input bit t, input string tag);
    for (int i = 0; i < n; i++) step(t, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(5ns * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] r;
    seed = 7;
    r = $urandom(seed);
    m_armed = 0; m_cnt = 0; m_flag = 0; m_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");

    // R2 exact timing with N=3, pin function on (R8)
    wdo_en = 1;
    step(0, 1, 32'd3, 0, 0, "R2");
    chk("R8", 32'(wdo_out), 32'd1, "pin high while counting");
    step(1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R2");
    chk("R2", 32'(rst_req), 32'd0, "no early request");
    step(1, 0, 0, 0, 0, "R2");
    chk("R2", 32'(rst_req), 32'd1, "request after Nth tick");
    chk("R6", 32'(sts_flag), 32'd1, "flag with request");
    chk("R8", 32'(wdo_out), 32'd0, "pin low after expiry");
    // R5 pulse length, R9 no re-expiry
    idle(3, 1, "R5");
    chk("R5", 32'(rst_req), 32'd1, "fourth cycle high");
    idle(1, 1, "R5");
    chk("R5", 32'(rst_req), 32'd0, "low after four");
    idle(10, 1, "R9");
    chk("R6", 32'(sts_flag), 32'd1, "flag survives");
    // R7 clear with wrong bit ignored, then proper clear
    step(0, 0, 0, 1, 32'h4000_0000, "R7");
    chk("R7", 32'(sts_flag), 32'd1, "bit30 ignored");
    step(0, 0, 0, 1, 32'h8000_0000, "R7");
    chk("R7", 32'(sts_flag), 32'd0, "bit31 clears");

    // R3 keep-alive on final tick
    step(0, 1, 32'd2, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R3");
    step(1, 1, 32'd2, 0, 0, "R3");
    chk("R3", 32'(rst_req), 32'd0, "write wins over last tick");
    step(1, 0, 0, 0, 0, "R3");
    chk("R3", 32'(rst_req), 32'd0, "reloaded count");
    step(1, 0, 0, 0, 0, "R3");
    chk("R3", 32'(rst_req), 32'd1, "expiry after reload");
    idle(6, 0, "R5");

    // R7 clear collides with expiry: set wins
    step(0, 0, 0, 1, 32'h8000_0000, "R7");
    step(0, 1, 32'd1, 0, 0, "R7");
    step(1, 0, 0, 1, 32'h8000_0000, "R7");
    chk("R7", 32'(sts_flag), 32'd1, "set beats clear");
    idle(6, 0, "R5");

    // R4 zero write disables
    step(0, 0, 0, 1, 32'hFFFF_FFFF, "R4");
    step(0, 1, 32'd2, 0, 0, "R4");
    step(1, 1, 32'd0, 0, 0, "R4");
    idle(20, 1, "R4");
    chk("R4", 32'(rst_req), 32'd0, "stopped");
    chk("R8", 32'(wdo_out), 32'd0, "pin low when stopped");
    wdo_en = 0;
    idle(1, 0, "R8");
    chk("R8", 32'(wdo_oe), 32'd0, "oe follows enable");

    // random phase checked against model
    for (int i = 0; i < 4000; i++) begin
      bit t, w, s;
      logic [31:0] wd, sd;
      t  = ($urandom % 2) == 0;
      w  = ($urandom % 30) == 0;
      wd = (($urandom % 8) == 0) ? 32'd0 : 32'(1 + $urandom % 12);
      s  = ($urandom % 25) == 0;
      sd = $urandom;
      if (($urandom % 100) == 0) wdo_en = ~wdo_en;
      step(t, w, wd, s, sd, "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule